// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of an SDRAM interface and owns the command pins from reset until the memory is usable. After reset it drives only no-operation commands while clock enable and the data mask are held high for a long start-up wait. It then closes every bank, programs the mode register from a supplied mode word, and issues a fixed number of auto refresh commands. Each command is followed by the no-operation gap that its recovery time needs. When the sequence is done it raises a ready flag.

From then on, an interval timer requests one auto refresh per period. The period defaults to the 64 ms / 4096-row budget at the configured clock rate. Requests that cannot be served at once are counted up to a saturating limit and issued back to back later. While any refresh is owed or in progress, a busy flag tells the user access port to hold off. The sequencer waits until the user side reports that no access is in flight. If a bank is still open, it closes all banks first and waits out the row-precharge time before refreshing.

All timings are parameters in clock cycles. A parameter chooses whether the mode set comes before or after the start-up refreshes.

Top module: `sdr_boot_refresh_seq`

## Requirements
- R1: After reset the block issues no-operation commands (command code {cs,ras,cas,we} = 0111) for exactly WAIT_CYC cycles, with `cke_o` and `dqm_o` high.
- R2: After the start-up wait, the order is: precharge-all, then mode set, then INIT_REFS auto refreshes (code 0001). With MRS_FIRST=0 the refreshes come before the mode set.
- R3: Mode set is code 0000. The address carries the mode word with its top RSV_BITS bits forced to zero, and the next command comes T_MRD cycles later.
- R4: Precharge-all is code 0010 with address bit AP_BIT (10) high and all other address bits low. The next command comes T_RP cycles later.
- R5: Every auto refresh is followed by T_RC-1 no-operation cycles. The address is zero for all commands except mode set and precharge-all.
- R6: Once ready, one refresh is owed every REF_INTERVAL cycles. Owed refreshes are counted up to MAX_PEND, and further requests are dropped at that limit. After a refresh recovery ends with refreshes still owed, the next auto refresh follows at once.
- R7: `ready_o` is low until the last start-up recovery has ended, then stays high.
- R8: `busy_o` is high, once ready, whenever a refresh is owed or a refresh or precharge sequence is running. A new refresh sequence starts only in a cycle where `user_idle_i` is high.
- R9: If `bank_open_i` is high when a refresh sequence starts, a precharge-all is issued first, and the auto refresh follows T_RP cycles later.
- R10: `cke_o` stays high at all times, and `dqm_o` is low once ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_word_i | input | ADDR_W | Mode register value to program |
| user_idle_i | input | 1 | User port has no access in flight |
| bank_open_i | input | 1 | At least one bank is open |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Address pins |
| cke_o | output | 1 | Clock enable |
| dqm_o | output | 1 | Data mask |
| ready_o | output | 1 | Start-up sequence complete |
| busy_o | output | 1 | User commands must be held off |

## Verification
The bench holds `user_idle_i` low across many intervals so that the owed count saturates. A counter that wraps or does not stop at its limit would then issue the wrong number of back-to-back refreshes when the port frees up. It raises `bank_open_i` at refresh time, so a design that skipped the precharge-all, or cut the row-precharge gap short, shows a refresh one or more cycles early. A second instance uses the swapped start-up order. The mode word has its reserved top bits set, which catches a design that passes them through to the address pins. It also toggles `user_idle_i` rapidly, which catches a sequencer that starts a refresh while the port is still in use or that drops busy one cycle early.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS  = 4'b0000,
    CMD_AREF = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_NOP  = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_PWR, ST_PRE, ST_MRS, ST_AREF, ST_WAIT, ST_IDLE
  } seq_st_e;
endpackage

// File: rtl/sdr_interval_timer.sv
module sdr_interval_timer #(
  parameter int PERIOD = 3125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sdr_debt_counter.sv
module sdr_debt_counter #(
  parameter int MAX = 8,
  localparam int CW = $clog2(MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          nz_o
);
  localparam logic [CW-1:0] TOP = CW'(MAX);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_i && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
  assign nz_o  = (cnt_q != '0);
endmodule

// File: rtl/sdr_delay_counter.sv
module sdr_delay_counter #(
  parameter int W       = 16,
  parameter int RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= W'(RST_VAL);
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdr_boot_refresh_seq.sv
module sdr_boot_refresh_seq #(
  parameter int ADDR_W       = 12,
  parameter int CLK_MHZ      = 200,
  parameter int WAIT_CYC     = 200 * CLK_MHZ,
  parameter int REF_INTERVAL = (64000 * CLK_MHZ) / 4096,
  parameter int T_RP         = 3,
  parameter int T_RC         = 14,
  parameter int T_MRD        = 2,
  parameter int INIT_REFS    = 8,
  parameter int MAX_PEND     = 8,
  parameter int RSV_BITS     = 2,
  parameter int AP_BIT       = 10,
  parameter bit MRS_FIRST    = 1'b1,
  localparam int PEND_W      = $clog2(MAX_PEND + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] mode_word_i,
  input  logic              user_idle_i,
  input  logic              bank_open_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cke_o,
  output logic              dqm_o,
  output logic              ready_o,
  output logic              busy_o
);
  import sdr_seq_pkg::*;

  // T_RP, T_RC, T_MRD must be at least 2
  localparam int MAXT0 = (T_RC > T_RP) ? T_RC : T_RP;
  localparam int MAXT1 = (MAXT0 > T_MRD) ? MAXT0 : T_MRD;
  localparam int MAXT  = (MAXT1 > WAIT_CYC) ? MAXT1 : WAIT_CYC;
  localparam int DW    = $clog2(MAXT + 1);
  localparam int RW    = $clog2(INIT_REFS + 1);
  localparam logic [DW-1:0] RP_LD  = DW'(T_RP - 2);
  localparam logic [DW-1:0] RC_LD  = DW'(T_RC - 2);
  localparam logic [DW-1:0] MRD_LD = DW'(T_MRD - 2);
  localparam logic [ADDR_W-1:0] MODE_MASK = {{RSV_BITS{1'b0}}, {(ADDR_W-RSV_BITS){1'b1}}};
  localparam logic [ADDR_W-1:0] AP_ADDR   = ADDR_W'(1) << AP_BIT;

  seq_st_e state_q, state_d, ret_q, ret_d;
  logic [RW-1:0] refs_q;
  logic ready_q;
  logic tick, pend_nz, dly_zero, dly_load;
  logic [DW-1:0] dly_val;
  logic [PEND_W-1:0] pend_cnt;
  sdr_cmd_e cmd;

  sdr_interval_timer #(.PERIOD(REF_INTERVAL)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ready_q), .tick_o(tick)
  );

  sdr_debt_counter #(.MAX(MAX_PEND)) u_debt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(tick),
    .dec_i(ready_q && state_q == ST_AREF),
    .cnt_o(pend_cnt), .nz_o(pend_nz)
  );

  sdr_delay_counter #(.W(DW), .RST_VAL(WAIT_CYC - 1)) u_delay (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(dly_load),
    .load_val_i(dly_val), .zero_o(dly_zero)
  );

  always_comb begin
    state_d  = state_q;
    ret_d    = ret_q;
    dly_load = 1'b0;
    dly_val  = '0;
    unique case (state_q)
      ST_PWR:  if (dly_zero) state_d = ST_PRE;
      ST_PRE:  begin dly_load = 1'b1; dly_val = RP_LD;  ret_d = ST_PRE;  state_d = ST_WAIT; end
      ST_MRS:  begin dly_load = 1'b1; dly_val = MRD_LD; ret_d = ST_MRS;  state_d = ST_WAIT; end
      ST_AREF: begin dly_load = 1'b1; dly_val = RC_LD;  ret_d = ST_AREF; state_d = ST_WAIT; end
      ST_WAIT: if (dly_zero) begin
        case (ret_q)
          ST_PRE: state_d = (ready_q || !MRS_FIRST) ? ST_AREF : ST_MRS;
          ST_MRS: state_d = MRS_FIRST ? ST_AREF : ST_IDLE;
          default: begin
            if (ready_q)          state_d = pend_nz ? ST_AREF : ST_IDLE;
            else if (refs_q != 0) state_d = ST_AREF;
            else                  state_d = MRS_FIRST ? ST_IDLE : ST_MRS;
          end
        endcase
      end
      ST_IDLE: if (pend_nz && user_idle_i) state_d = bank_open_i ? ST_PRE : ST_AREF;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWR;
      ret_q   <= ST_PRE;
      refs_q  <= RW'(INIT_REFS);
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      if (!ready_q && state_q == ST_AREF && refs_q != 0) refs_q <= refs_q - 1'b1;
      if (state_d == ST_IDLE) ready_q <= 1'b1;
    end
  end

  always_comb begin
    cmd    = CMD_NOP;
    addr_o = '0;
    case (state_q)
      ST_PRE:  begin cmd = CMD_PRE; addr_o = AP_ADDR; end
      ST_MRS:  begin cmd = CMD_MRS; addr_o = mode_word_i & MODE_MASK; end
      ST_AREF: cmd = CMD_AREF;
      default: cmd = CMD_NOP;
    endcase
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
  assign cke_o   = 1'b1;
  assign dqm_o   = !ready_q;
  assign ready_o = ready_q;
  assign busy_o  = ready_q && (pend_nz || state_q != ST_IDLE);
endmodule

// File: rtl/sdr_boot_refresh_seq_chk.sv
module sdr_boot_refresh_seq_chk #(
  parameter int ADDR_W   = 12,
  parameter int RSV_BITS = 2,
  parameter int AP_BIT   = 10,
  parameter int MAX_PEND = 8,
  parameter int PEND_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        cmd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              cke_i,
  input logic              dqm_i,
  input logic              ready_i,
  input logic              busy_i,
  input logic [PEND_W-1:0] pend_i
);
  p_cke_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni) cke_i);
  p_ready_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni) ready_i |=> ready_i);
  p_mask_boot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni) !ready_i |-> dqm_i);
  p_aref_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni) cmd_i == 4'b0001 |=> cmd_i == 4'b0111);
  p_pre_ap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni) cmd_i == 4'b0010 |-> addr_i[AP_BIT]);
  p_mrs_rsv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == 4'b0000 |-> addr_i[ADDR_W-1 -: RSV_BITS] == '0);
  p_busy_ref_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && cmd_i == 4'b0001) |-> busy_i);
  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni) pend_i <= PEND_W'(MAX_PEND));
endmodule

bind sdr_boot_refresh_seq sdr_boot_refresh_seq_chk #(
  .ADDR_W(ADDR_W), .RSV_BITS(RSV_BITS), .AP_BIT(AP_BIT),
  .MAX_PEND(MAX_PEND), .PEND_W(PEND_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .cmd_i({cs_n_o, ras_n_o, cas_n_o, we_n_o}), .addr_i(addr_o),
  .cke_i(cke_o), .dqm_i(dqm_o), .ready_i(ready_o), .busy_i(busy_o),
  .pend_i(pend_cnt)
);

// File: tb/sdr_boot_refresh_seq_bench.sv
module sdr_ref_model #(
  parameter int WAIT_CYC = 20, parameter int T_RP = 3, parameter int T_RC = 5,
  parameter int T_MRD = 2, parameter int INTERVAL = 60, parameter int NREF = 8,
  parameter int MAXP = 8, parameter bit MRS_FIRST = 1'b1
) (
  input  logic       clk, rst_n, user_idle, bank_open,
  output logic [3:0] exp_cmd,
  output logic       exp_ready, exp_busy
);
  logic [3:0] q[$];
  int pend_m, tmr_m;
  bit ready_m, was_idle, tick, dec;
  logic [3:0] cmd_now;

  task automatic put(input logic [3:0] c, input int gap);
    q.push_back(c);
    for (int i = 1; i < gap; i++) q.push_back(4'b0111);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      for (int i = 0; i < WAIT_CYC; i++) q.push_back(4'b0111);
      put(4'b0010, T_RP);
      if (MRS_FIRST) put(4'b0000, T_MRD);
      for (int i = 0; i < NREF; i++) put(4'b0001, T_RC);
      if (!MRS_FIRST) put(4'b0000, T_MRD);
      ready_m = 0; pend_m = 0; tmr_m = 0;
    end else begin
      was_idle = ready_m && q.size() == 0;
      tick = ready_m && tmr_m == INTERVAL - 1;
      tmr_m = (!ready_m || tick) ? 0 : tmr_m + 1;
      cmd_now = 4'b0111;
      if (q.size() != 0) cmd_now = q.pop_front();
      dec = ready_m && cmd_now == 4'b0001;
      if (!ready_m && q.size() == 0) ready_m = 1;
      else if (was_idle && pend_m != 0 && user_idle) begin
        if (bank_open) put(4'b0010, T_RP);
        put(4'b0001, T_RC);
      end else if (ready_m && !was_idle && q.size() == 0 && pend_m != 0) put(4'b0001, T_RC);
      if (tick && !dec && pend_m < MAXP) pend_m++;
      else if (dec && !tick && pend_m > 0) pend_m--;
    end
    exp_cmd   = (q.size() != 0) ? q[0] : 4'b0111;
    exp_ready = ready_m;
    exp_busy  = ready_m && (pend_m != 0 || q.size() != 0);
  end
endmodule

module sdr_boot_refresh_seq_bench;
  localparam int AW = 12;
  logic clk = 0, rst_n = 0, user_idle = 1, bank_open = 0;
  int n_checks = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  logic [AW-1:0] mode_a = 12'hFFF, mode_b = 12'hC5A;
  logic cs_a, ras_a, cas_a, we_a, cke_a, dqm_a, rdy_a, bsy_a;
  logic cs_b, ras_b, cas_b, we_b, cke_b, dqm_b, rdy_b, bsy_b;
  logic [AW-1:0] addr_a, addr_b;
  logic [3:0] ecmd_a, ecmd_b;
  logic erdy_a, ebsy_a, erdy_b, ebsy_b;

  sdr_boot_refresh_seq #(.ADDR_W(AW), .WAIT_CYC(20), .REF_INTERVAL(60), .T_RP(3),
    .T_RC(5), .T_MRD(2), .INIT_REFS(8), .MAX_PEND(8), .MRS_FIRST(1'b1)) u_sdr_boot_refresh_seq (
    .clk_i(clk), .rst_ni(rst_n), .mode_word_i(mode_a), .user_idle_i(user_idle),
    .bank_open_i(bank_open), .cs_n_o(cs_a), .ras_n_o(ras_a), .cas_n_o(cas_a), .we_n_o(we_a),
    .addr_o(addr_a), .cke_o(cke_a), .dqm_o(dqm_a), .ready_o(rdy_a), .busy_o(bsy_a));

  sdr_boot_refresh_seq #(.ADDR_W(AW), .WAIT_CYC(20), .REF_INTERVAL(60), .T_RP(3),
    .T_RC(5), .T_MRD(2), .INIT_REFS(8), .MAX_PEND(8), .MRS_FIRST(1'b0)) u_alt (
    .clk_i(clk), .rst_ni(rst_n), .mode_word_i(mode_b), .user_idle_i(user_idle),
    .bank_open_i(bank_open), .cs_n_o(cs_b), .ras_n_o(ras_b), .cas_n_o(cas_b), .we_n_o(we_b),
    .addr_o(addr_b), .cke_o(cke_b), .dqm_o(dqm_b), .ready_o(rdy_b), .busy_o(bsy_b));

  sdr_ref_model #(.MRS_FIRST(1'b1)) m_a (.clk(clk), .rst_n(rst_n), .user_idle(user_idle),
    .bank_open(bank_open), .exp_cmd(ecmd_a), .exp_ready(erdy_a), .exp_busy(ebsy_a));
  sdr_ref_model #(.MRS_FIRST(1'b0)) m_b (.clk(clk), .rst_n(rst_n), .user_idle(user_idle),
    .bank_open(bank_open), .exp_cmd(ecmd_b), .exp_ready(erdy_b), .exp_busy(ebsy_b));

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [3:0] c, input logic [AW-1:0] m);
    if (c == 4'b0010) return 12'h400;          // R4 bit 10
    if (c == 4'b0000) return m & 12'h3FF;      // R3 top two bits zero
    return '0;                                  // R5
  endfunction

  function automatic string cmd_tag(input logic [3:0] c, input logic rdy);
    if (c == 4'b0000) return "R3 mode set";
    if (c == 4'b0010) return rdy ? "R9 precharge before refresh" : "R4 precharge-all";
    if (c == 4'b0001) return rdy ? "R6 periodic refresh" : "R2 start-up refresh";
    return rdy ? "R5 recovery gap" : "R1 power-up nop";
  endfunction

  task automatic cmp_one(input string who, input logic [3:0] act_c, input logic [3:0] ec,
                         input logic [AW-1:0] act_a, input logic [AW-1:0] m,
                         input logic cke, dqm, rdy, bsy, erdy, ebsy);
    chk({who, " ", cmd_tag(ec, erdy)}, act_c, ec);
    chk({who, " R3/R4 address"}, act_a, exp_addr(ec, m));
    chk({who, " R10 cke"}, cke, 1);
    chk({who, erdy ? " R10 dqm" : " R1 dqm"}, dqm, !erdy);
    chk({who, " R7 ready"}, rdy, erdy);
    chk({who, " R8 busy"}, bsy, ebsy);
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    cmp_one("A", {cs_a, ras_a, cas_a, we_a}, ecmd_a, addr_a, mode_a, cke_a, dqm_a, rdy_a, bsy_a, erdy_a, ebsy_a);
    cmp_one("B", {cs_b, ras_b, cas_b, we_b}, ecmd_b, addr_b, mode_b, cke_b, dqm_b, rdy_b, bsy_b, erdy_b, ebsy_b);
  end

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state, R1 R7
    chk("R1 reset nop A", {cs_a, ras_a, cas_a, we_a}, 4'b0111);
    chk("R7 reset ready A", rdy_a, 0);
    chk("R1 reset dqm B", dqm_b, 1);
    rst_n = 1;
    repeat (365) @(negedge clk);            // R2 R6: free port, no open bank
    bank_open = 1; repeat (200) @(negedge clk);   // R9
    user_idle = 0; repeat (700) @(negedge clk);   // R6 saturation, R8 hold-off
    user_idle = 1; repeat (300) @(negedge clk);   // R6 back-to-back drain
    bank_open = 0;
    for (int i = 0; i < 60; i++) begin            // R8 idle toggling
      user_idle = ~user_idle;
      repeat (7) @(negedge clk);
    end
    user_idle = 1; repeat (100) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule